// File: doc/BRIEF.md
# Evaluation Stabilization Controller

This block sequences the repeated evaluation of one entity on a time-multiplexed evaluation unit. That unit contains chains of memories with asynchronous reads. Each extra pass lets one more stage of such a chain see a correct address. The controller issues evaluate requests one at a time and collects each result vector. It decides when the entity's outputs have settled, then signals completion and returns to idle.

Two rules decide when to stop, and whichever fires first ends the run. The first rule is a fixed count. The number of accepted evaluations since the last input change reaches the chain depth, which software loads into a register while the block is idle. The second rule is early termination. An accepted result equals the previous accepted result, and the inputs have not changed in between.

An input-change pulse during a run restarts both the count and the comparison. Any result already in flight is discarded.

Top module: `evalSettle`

## Requirements
- R1: After reset, evalReq is 0, done is 0 and evalCount is 0, and the block is idle.
- R2: A start pulse seen while idle raises evalReq for exactly one cycle, in the cycle after start is sampled. A start pulse during a run has no effect on the sequence of requests.
- R3: A result is accepted when evalValid is high while the block waits for a result. evalCount rises by one per accepted result. If the run continues, evalReq is high in the cycle after the accepted result.
- R4: With a loaded chain depth L of 1 or more, the run ends when evalCount reaches L, unless an earlier stop applies.
- R5: A loaded chain depth of 0 ends the run after a single accepted evaluation.
- R6: The run ends early when an accepted result equals the previous accepted result and no input change has occurred since that previous result.
- R7: inChg during a run clears evalCount to 0 in the next cycle and forgets the previous result. A result arriving in the same cycle as inChg, or after it but before the next request, is discarded and a new request is issued.
- R8: done is high for exactly one cycle, in the cycle after the final accepted result. evalReq stays low afterwards until the next start. evalCount holds its final value until the next start clears it.
- R9: cfgLoad loads cfgLen as the chain depth only while idle. A load attempted during a run is ignored.
- R10: While idle, inChg and evalValid have no effect: no request is raised and evalCount keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin evaluating one entity |
| inChg | input | 1 | Pulse: the entity's inputs have changed |
| cfgLoad | input | 1 | Load cfgLen as chain depth (idle only) |
| cfgLen | input | CNT_W | Longest asynchronous chain depth |
| evalValid | input | 1 | Result of the pending evaluation is present |
| evalOut | input | OUT_W | Output vector of the evaluation |
| evalReq | output | 1 | Strobe: perform one evaluation |
| done | output | 1 | One-cycle pulse: outputs have settled |
| evalCount | output | CNT_W | Accepted evaluations since start or last input change |

## Verification
The hardest case to reach is an input change that lands while a request is in flight. The stale result must be dropped, and the remembered output must be forgotten. The bench creates this case by waiting until the first result has been accepted and pulsing inChg in the very next request cycle. It feeds identical output vectors throughout, so that a failure to forget would end the run too soon. A cycle-level behavioural model then checks evalReq, done and evalCount on every clock. Directed checks confirm the total number of requests and the final count.

// File: rtl/evalSettlePkg.sv
package evalSettlePkg;
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} ctlState_t;

  typedef struct packed {
    logic clear;    // drop count and remembered output
    logic accept;   // count a result and remember it
    logic cfgOpen;  // chain depth may be loaded
  } ctlStb_t;
endpackage

// File: rtl/evalSettleDp.sv
module evalSettleDp
  import evalSettlePkg::*;
#(
  parameter int OUT_W = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStb_t          stb,
  input  logic             cfgLoad,
  input  logic [CNT_W-1:0] cfgLen,
  input  logic [OUT_W-1:0] evalOut,
  output logic             lastOne,
  output logic             sameOut,
  output logic [CNT_W-1:0] evalCount
);
  localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

  logic [CNT_W-1:0] chainLen;
  logic [CNT_W-1:0] cnt;
  logic [OUT_W-1:0] prevOut;
  logic             prevOk;
  logic [CNT_W:0]   cntNext;
  logic [CNT_W:0]   need;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainLen <= '0;
      cnt      <= '0;
      prevOut  <= '0;
      prevOk   <= 1'b0;
    end else begin
      if (stb.cfgOpen && cfgLoad) chainLen <= cfgLen;
      if (stb.clear) begin
        cnt    <= '0;
        prevOk <= 1'b0;
      end else if (stb.accept) begin
        cnt     <= cnt + 1'b1;
        prevOut <= evalOut;
        prevOk  <= 1'b1;
      end
    end
  end

  always_comb begin
    cntNext = {1'b0, cnt} + ONE;
    need    = (chainLen == '0) ? ONE : {1'b0, chainLen};
    lastOne = (cntNext >= need);
    sameOut = prevOk && (evalOut == prevOut);
  end

  assign evalCount = cnt;
endmodule

// File: rtl/evalSettleCtl.sv
module evalSettleCtl
  import evalSettlePkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    inChg,
  input  logic    evalValid,
  input  logic    lastOne,
  input  logic    sameOut,
  output ctlStb_t stb,
  output logic    evalReq,
  output logic    done
);
  ctlState_t st, stNext;
  logic      stale, staleNext;
  logic      finish;

  always_comb begin
    stNext     = st;
    staleNext  = stale;
    finish     = 1'b0;
    stb        = '0;
    stb.cfgOpen = (st == S_IDLE);
    case (st)
      S_IDLE: if (start) begin
        stb.clear = 1'b1;
        stNext    = S_REQ;
      end
      S_REQ: begin
        stNext = S_WAIT;
        if (inChg) begin
          stb.clear = 1'b1;
          staleNext = 1'b1;
        end
      end
      S_WAIT: begin
        if (evalValid) begin
          if (inChg || stale) begin
            stb.clear = 1'b1;
            staleNext = 1'b0;
            stNext    = S_REQ;
          end else begin
            stb.accept = 1'b1;
            if (lastOne || sameOut) begin
              finish = 1'b1;
              stNext = S_IDLE;
            end else begin
              stNext = S_REQ;
            end
          end
        end else if (inChg) begin
          stb.clear = 1'b1;
          staleNext = 1'b1;
        end
      end
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st    <= S_IDLE;
      stale <= 1'b0;
      done  <= 1'b0;
    end else begin
      st    <= stNext;
      stale <= staleNext;
      done  <= finish;
    end
  end

  assign evalReq = (st == S_REQ);
endmodule

// File: rtl/evalSettle.sv
module evalSettle
  import evalSettlePkg::*;
#(
  parameter int OUT_W = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             inChg,
  input  logic             cfgLoad,
  input  logic [CNT_W-1:0] cfgLen,
  input  logic             evalValid,
  input  logic [OUT_W-1:0] evalOut,
  output logic             evalReq,
  output logic             done,
  output logic [CNT_W-1:0] evalCount
);
  ctlStb_t ctlStb;
  logic    lastOne;
  logic    sameOut;

  evalSettleCtl u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .inChg(inChg),
    .evalValid(evalValid), .lastOne(lastOne), .sameOut(sameOut),
    .stb(ctlStb), .evalReq(evalReq), .done(done)
  );

  evalSettleDp #(.OUT_W(OUT_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(ctlStb), .cfgLoad(cfgLoad),
    .cfgLen(cfgLen), .evalOut(evalOut), .lastOne(lastOne),
    .sameOut(sameOut), .evalCount(evalCount)
  );
endmodule

// File: rtl/evalSettleChk.sv
module evalSettleChk
  import evalSettlePkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             evalReq,
  input logic             done,
  input logic [CNT_W-1:0] evalCount,
  input ctlStb_t          stb
);
  p_req_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    evalReq |=> !evalReq);

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (evalCount != $past(evalCount)) |->
      (evalCount == '0 || evalCount == $past(evalCount) + 1'b1));

  p_done_counted_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> evalCount != '0);

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> evalCount == '0);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_quiet_after_r8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> !evalReq);
endmodule

bind evalSettle evalSettleChk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .evalReq(evalReq),
  .done(done), .evalCount(evalCount), .stb(ctlStb)
);

// File: tb/evalSettle_test.sv
`timescale 1ns/1ps
module evalSettle_test;
  localparam int OUT_W = 16;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, inChg = 1'b0, cfgLoad = 1'b0;
  logic [CNT_W-1:0] cfgLen = '0;
  logic respValid = 1'b0, pokeValid = 1'b0;
  logic [OUT_W-1:0] evalOut = '0;
  logic evalValid;
  logic evalReq, done;
  logic [CNT_W-1:0] evalCount;

  assign evalValid = respValid | pokeValid;
  always #2.5 clk = ~clk;

  evalSettle #(.OUT_W(OUT_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .inChg(inChg), .cfgLoad(cfgLoad),
    .cfgLen(cfgLen), .evalValid(evalValid), .evalOut(evalOut),
    .evalReq(evalReq), .done(done), .evalCount(evalCount)
  );

  int compared = 0, mismatched = 0;
  int cycles = 0;
  bit started = 0;

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference, advanced on each rising edge.
  int ms = 0, mc = 0, ml = 0, mDone = 0, mStale = 0, mPrevOk = 0;
  int mPrev = 0;
  always @(posedge clk) begin
    int need;
    if (!rstN) begin
      ms = 0; mc = 0; ml = 0; mDone = 0; mStale = 0; mPrevOk = 0; mPrev = 0;
    end else begin
      started = 1;
      mDone = 0;
      if (ms == 0 && cfgLoad) ml = int'(cfgLen);
      if (ms == 0) begin
        if (start) begin ms = 1; mc = 0; mPrevOk = 0; end
      end else if (ms == 1) begin
        ms = 2;
        if (inChg) begin mc = 0; mPrevOk = 0; mStale = 1; end
      end else begin
        if (evalValid) begin
          if (inChg || mStale != 0) begin
            mc = 0; mPrevOk = 0; mStale = 0; ms = 1;
          end else begin
            need = (ml == 0) ? 1 : ml;
            mc++;
            if (mc >= need || (mPrevOk != 0 && int'(evalOut) == mPrev)) begin
              ms = 0; mDone = 1;
            end else ms = 1;
            mPrev = int'(evalOut); mPrevOk = 1;
          end
        end else if (inChg) begin
          mc = 0; mPrevOk = 0; mStale = 1;
        end
      end
    end
  end

  // Per-cycle comparison and evaluation responder, away from the rising edge.
  int lat = 1, waitCnt = 0, seqIdx = 0, reqSeen = 0;
  logic [OUT_W-1:0] seqVal [16];
  always @(negedge clk) begin
    cycles++;
    if (started && rstN) begin
      check("R2 evalReq", int'(evalReq), (ms == 1) ? 1 : 0);
      check("R8 done", int'(done), mDone);
      check("R3 evalCount", int'(evalCount), mc);
    end
    respValid <= 1'b0;
    if (waitCnt > 0) begin
      waitCnt--;
      if (waitCnt == 0) begin
        respValid <= 1'b1;
        evalOut   <= seqVal[seqIdx % 16];
        seqIdx++;
      end
    end
    if (evalReq) begin waitCnt = lat; reqSeen++; end
  end

  task automatic loadLen(input int l);
    @(negedge clk); cfgLoad = 1'b1; cfgLen = CNT_W'(l);
    @(negedge clk); cfgLoad = 1'b0;
  endtask

  task automatic setSeq(input int base, input int step);
    for (int i = 0; i < 16; i++) seqVal[i] = OUT_W'(base + i * step);
    seqIdx = 0;
  endtask

  task automatic kick();
    @(negedge clk); reqSeen = 0; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitDone(input string req, input int expReqs, input int expCnt);
    int n = 0;
    while (done !== 1'b1 && n < 300) begin @(negedge clk); n++; end
    check({req, " done seen"}, int'(done === 1'b1), 1);
    check({req, " request total"}, reqSeen, expReqs);
    check({req, " final count"}, int'(evalCount), expCnt);
    @(negedge clk);
    check("R8 done one cycle", int'(done), 0);
    check("R8 count held", int'(evalCount), expCnt);
  endtask

  initial begin : watchdog
    wait (cycles > 100000);
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 evalReq", int'(evalReq), 0);
    check("R1 done", int'(done), 0);
    check("R1 evalCount", int'(evalCount), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R4, R2: depth 3, distinct outputs, extra start mid-run ignored.
    loadLen(3); setSeq(1, 1); lat = 1;
    kick();
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    waitDone("R4", 3, 3);

    // R5: depth 0 gives one evaluation.
    loadLen(0); setSeq(20, 3); lat = 2;
    kick(); waitDone("R5", 1, 1);

    // R6: equal consecutive outputs stop before the depth.
    loadLen(5); setSeq(7, 0); lat = 1;
    kick(); waitDone("R6 pair", 2, 2);
    loadLen(4); seqVal[0] = 1; seqVal[1] = 2; seqVal[2] = 2; seqIdx = 0;
    kick(); waitDone("R6 late", 3, 3);

    // R9: load during a run is ignored.
    loadLen(2); setSeq(40, 1); lat = 1;
    kick(); cfgLoad = 1'b1; cfgLen = CNT_W'(9);
    @(negedge clk); cfgLoad = 1'b0;
    waitDone("R9", 2, 2);

    // R7: input change right after first result; identical outputs throughout.
    loadLen(3); setSeq(8, 0); lat = 2;
    kick();
    while (evalCount != CNT_W'(1)) @(negedge clk);
    inChg = 1'b1; @(negedge clk); inChg = 1'b0;
    check("R7 count cleared", int'(evalCount), 0);
    waitDone("R7", 4, 2);

    // R10: idle ignores input change and stray results.
    inChg = 1'b1; pokeValid = 1'b1; evalOut = 16'h55;
    @(negedge clk); inChg = 1'b0; pokeValid = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R10 no request", int'(evalReq), 0);
      check("R10 count kept", int'(evalCount), 2);
    end

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule